// File: doc/BRIEF.md
# Right-Justified Stereo Serial Audio Receiver

This block takes a three-wire serial audio stream (frame clock, bit clock and data) and turns it into parallel stereo sample pairs. The frame clock is high for the left channel and low for the right channel. In each LRCK period the left half comes first and the right half follows. Each channel word is sent most significant bit first. The word is packed against the end of its half-frame, so its least significant bit sits in the last bit-clock period before the frame clock changes level. The bit clock can run at any rate that gives at least one full word per half-frame, for example 32, 48, 64 or 72 bits per frame period. Any bits that arrive before the word are padding, and the block drops them.

All three serial inputs are brought into the system clock domain through two-flop synchronisers. Edges are then found there. A bit is taken on each rising bit-clock edge, and a frame-clock edge closes the half-frame that was running. A completed left/right pair is offered on a valid/ready output. The valid signal stays high until the consumer takes the pair, and the pair does not change while valid is high and ready is low. If a newer pair completes before the held one is taken, the newer pair replaces it. A consumer that keeps ready high therefore sees valid as a one-cycle strobe per frame. A half-frame that ends with fewer bits than a full word sets a sticky error flag.

Top module: `rj_audio_rx`

## Requirements
- R1: While rst_n is low and after reset, out_valid is 0, short_err is 0 and out_left and out_right are all zeros.
- R2: Data is taken on rising edges of sclk_in, and the first bit of a half-frame is the most significant bit of the word.
- R3: The word for a channel is the last WORD_W bits that arrive before the lrck_in edge ending that half-frame. Earlier bits are discarded, whatever the number of bit clocks per half-frame.
- R4: The half-frame with lrck_in high is left and the half-frame with lrck_in low is right. A pair is presented only when a rising lrck_in edge ends a right half that followed a captured left half.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_left/out_right stay unchanged unless a newer pair completes, in which case the newer pair replaces them. A transfer takes place on a clock edge where out_valid and out_ready are both high.
- R6: If a half-frame ends after fewer than WORD_W rising bit-clock edges, short_err becomes 1 and stays 1 until reset. The word output is then the bits received, right aligned, with zeros above them.
- R7: The first lrck_in edge after reset only opens a half-frame. It produces no pair and no error.
- R8: WORD_W sets the word length. With WORD_W=16 the outputs carry the last 16 bits of each half-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| lrck_in | input | 1 | Frame clock, high for left and low for right, asynchronous to clk |
| sclk_in | input | 1 | Bit clock, asynchronous to clk |
| sdata_in | input | 1 | Serial data, valid at rising sclk_in |
| out_ready | input | 1 | Consumer accepts the held pair |
| out_valid | output | 1 | A stereo pair is held on out_left/out_right |
| out_left | output | WORD_W | Left channel word |
| out_right | output | WORD_W | Right channel word |
| short_err | output | 1 | Sticky flag: a half-frame was shorter than one word |

## Verification
The bench builds two copies side by side on the same serial lines: one with WORD_W=24 and one with WORD_W=16. Frames of 32, 24, 36 and 16 bits per half let one stream show several things: padding being dropped on both widths, an exact fit, and a short half that only the 24-bit copy sees as short. Back-pressure is exercised on the 24-bit copy alone, while the 16-bit copy keeps draining. This makes the overwrite of a held pair observable.

// File: rtl/rj_rx_pkg.sv
package rj_rx_pkg;
  typedef enum logic [1:0] {
    HALF_NONE      = 2'd0,
    HALF_LEFT_END  = 2'd1,
    HALF_RIGHT_END = 2'd2
  } half_evt_e;
endpackage

// File: rtl/rj_sync.sv
module rj_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rj_edge_det.sv
module rj_edge_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] chg
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign chg = lvl ^ prev_q;
endmodule

// File: rtl/rj_word_shifter.sv
module rj_word_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              half_end,
  output logic [WORD_W-1:0] word,
  output logic              full
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (half_end) begin
      // a bit arriving with the edge belongs to the new half
      shift_q <= bit_stb ? {{(WORD_W-1){1'b0}}, bit_val} : '0;
      cnt_q   <= bit_stb ? CNT_W'(1) : '0;
    end else if (bit_stb) begin
      shift_q <= {shift_q[WORD_W-2:0], bit_val};
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign word = shift_q;
  assign full = (cnt_q == CNT_MAX);
endmodule

// File: rtl/rj_frame_assembler.sv
module rj_frame_assembler
  import rj_rx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  half_evt_e         evt,
  input  logic [WORD_W-1:0] word,
  input  logic              full,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_left,
  output logic [WORD_W-1:0] out_right,
  output logic              short_err,
  output logic              frame_load
);
  logic              armed_q;
  logic              have_left_q;
  logic [WORD_W-1:0] left_hold_q;

  assign frame_load = armed_q && have_left_q && (evt == HALF_RIGHT_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      have_left_q <= 1'b0;
      left_hold_q <= '0;
      out_valid   <= 1'b0;
      out_left    <= '0;
      out_right   <= '0;
      short_err   <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (evt != HALF_NONE) begin
        if (!armed_q) begin
          armed_q     <= 1'b1;
          have_left_q <= 1'b0;
        end else begin
          if (!full) short_err <= 1'b1;
          if (evt == HALF_LEFT_END) begin
            left_hold_q <= word;
            have_left_q <= 1'b1;
          end else begin
            have_left_q <= 1'b0;
          end
        end
      end
      if (frame_load) begin
        out_left  <= left_hold_q;
        out_right <= word;
        out_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rj_audio_rx.sv
module rj_audio_rx
  import rj_rx_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lrck_in,
  input  logic              sclk_in,
  input  logic              sdata_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_left,
  output logic [WORD_W-1:0] out_right,
  output logic              short_err
);
  localparam int LINES = 3;

  logic [LINES-1:0]  ser_s;
  logic [1:0]        clk_chg;
  logic              lrck_s, sclk_s, sdata_s;
  logic              lrck_rise, lrck_fall, bit_stb;
  logic              frame_load;
  logic              full;
  logic [WORD_W-1:0] word;
  half_evt_e         evt;

  // all lines share one synchroniser depth so bits and edges stay aligned
  rj_sync #(.W(LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({lrck_in, sclk_in, sdata_in}),
    .q(ser_s)
  );

  assign {lrck_s, sclk_s, sdata_s} = ser_s;

  rj_edge_det #(.W(2)) edge_i (
    .clk(clk), .rst_n(rst_n),
    .lvl({lrck_s, sclk_s}),
    .chg(clk_chg)
  );

  assign bit_stb   = clk_chg[0] & sclk_s;
  assign lrck_rise = clk_chg[1] & lrck_s;
  assign lrck_fall = clk_chg[1] & ~lrck_s;

  always_comb begin
    if (lrck_fall)      evt = HALF_LEFT_END;
    else if (lrck_rise) evt = HALF_RIGHT_END;
    else                evt = HALF_NONE;
  end

  rj_word_shifter #(.WORD_W(WORD_W)) shift_i (
    .clk(clk), .rst_n(rst_n),
    .bit_stb(bit_stb), .bit_val(sdata_s),
    .half_end(lrck_rise | lrck_fall),
    .word(word), .full(full)
  );

  rj_frame_assembler #(.WORD_W(WORD_W)) asm_i (
    .clk(clk), .rst_n(rst_n),
    .evt(evt), .word(word), .full(full),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right),
    .short_err(short_err),
    .frame_load(frame_load)
  );
endmodule

// File: rtl/rj_audio_rx_chk.sv
module rj_audio_rx_chk #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_left,
  input logic [WORD_W-1:0] out_right,
  input logic              short_err,
  input logic              lrck_rise,
  input logic              lrck_fall,
  input logic              frame_load
);
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid); // R5

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !frame_load |=> $stable(out_left) && $stable(out_right)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    short_err |=> short_err); // R6

  AST_ERR_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_err) |-> $past(lrck_rise || lrck_fall)); // R6

  AST_PAIR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(lrck_rise)); // R4
endmodule

bind rj_audio_rx rj_audio_rx_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_left(out_left), .out_right(out_right),
  .short_err(short_err),
  .lrck_rise(lrck_rise), .lrck_fall(lrck_fall),
  .frame_load(frame_load)
);

// File: tb/rj_audio_rx_tb_top.sv
module rj_audio_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lrck = 1'b0, sclk = 1'b0, sdata = 1'b0;
  logic rdy24 = 1'b1;
  logic rdy16 = 1'b1;
  logic        vld24, err24, vld16, err16;
  logic [23:0] l24, r24;
  logic [15:0] l16, r16;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [47:0] q24[$];
  logic [31:0] q16[$];

  always #2.5 clk = ~clk;

  rj_audio_rx #(.WORD_W(24)) dut_i (
    .clk(clk), .rst_n(rst_n), .lrck_in(lrck), .sclk_in(sclk), .sdata_in(sdata),
    .out_ready(rdy24), .out_valid(vld24), .out_left(l24), .out_right(r24),
    .short_err(err24)
  );

  rj_audio_rx #(.WORD_W(16)) dut16_i (
    .clk(clk), .rst_n(rst_n), .lrck_in(lrck), .sclk_in(sclk), .sdata_in(sdata),
    .out_ready(rdy16), .out_valid(vld16), .out_left(l16), .out_right(r16),
    .short_err(err16)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] keep_low(input logic [63:0] v, input int nb, input int w);
    logic [63:0] m;
    int n;
    n = (nb < w) ? nb : w;
    m = (64'd1 << n) - 64'd1;
    return v & m;
  endfunction

  task automatic drive_half(input int nb, input logic lr, input logic [63:0] v);
    for (int i = nb - 1; i >= 0; i--) begin
      sclk = 1'b0;
      if (i == nb - 1) lrck = lr;
      sdata = v[i];
      #20;
      sclk = 1'b1;
      #20;
    end
  endtask

  // driver: sends one frame and pushes the expected pair for each width
  task automatic send_frame(input int nb, input logic [63:0] lv, input logic [63:0] rv);
    logic [63:0] a, b, c, d;
    drive_half(nb, 1'b1, lv);
    drive_half(nb, 1'b0, rv);
    a = keep_low(lv, nb, 24); b = keep_low(rv, nb, 24);
    c = keep_low(lv, nb, 16); d = keep_low(rv, nb, 16);
    q24.push_back({a[23:0], b[23:0]});
    q16.push_back({c[15:0], d[15:0]});
  endtask

  task automatic flush();
    sclk = 1'b0;
    lrck = 1'b1;
    #200;
  endtask

  // monitor: compares every transfer against the scoreboard
  always @(negedge clk) begin
    if (rst_n && vld24 && rdy24) begin
      if (q24.size() == 0) check(1'b0, "R4 unexpected 24-bit pair", {16'h0, l24, r24}, 64'h0);
      else begin
        logic [47:0] e;
        e = q24.pop_front();
        check({l24, r24} == e, "R2 R3 R4 24-bit pair", {16'h0, l24, r24}, {16'h0, e});
      end
    end
    if (rst_n && vld16 && rdy16) begin
      if (q16.size() == 0) check(1'b0, "R8 unexpected 16-bit pair", {32'h0, l16, r16}, 64'h0);
      else begin
        logic [31:0] e;
        e = q16.pop_front();
        check({l16, r16} == e, "R8 R3 16-bit pair", {32'h0, l16, r16}, {32'h0, e});
      end
    end
  end

  initial begin
    #(5 * 200000);
    if (!done) begin
      check(1'b0, "watchdog", 64'h0, 64'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] fa_l, fa_r, fb_l, fb_r;
    #51;
    check(!vld24 && !err24 && l24 == 0 && r24 == 0, "R1 reset 24", {err24, vld24, l24, r24}, 64'h0);
    check(!vld16 && !err16 && l16 == 0 && r16 == 0, "R1 reset 16", {err16, vld16, l16, r16}, 64'h0);
    #50 rst_n = 1'b1;
    #20;
    check(!vld24 && !err24, "R1 after reset", {vld24, err24}, 64'h0);

    // 64 bit clocks per frame: 8 padding bits lead each 24-bit word
    send_frame(32, 64'hDEAD_BEEF, 64'h1234_5678);
    send_frame(32, 64'h8000_0001, 64'h7FFF_FFFE);
    send_frame(32, 64'hA5C3_0F96, 64'h5A3C_F069);
    // 48 bit clocks per frame: exact 24-bit fit
    send_frame(24, 64'hF0_0F55, 64'h80_0001);
    send_frame(24, 64'h12_3456, 64'hFE_DCBA);
    // 72 bit clocks per frame
    send_frame(36, 64'hF_AB12_CD34, 64'h0_0FFF_0001);
    send_frame(36, 64'h9_7654_3210, 64'h6_8ACE_1357);
    flush();
    #1;
    check(!err24 && !err16, "R7 R3 no error on first edge or padding", {err24, err16}, 64'h0);

    // back-pressure on the 24-bit copy
    rdy24 = 1'b0;
    fa_l = 64'h00AB_CDEF; fa_r = 64'h0013_579B;
    fb_l = 64'h0024_68AC; fb_r = 64'h00FE_0102;
    send_frame(24, fa_l, fa_r);
    flush();
    #1;
    check(vld24 && l24 == fa_l[23:0] && r24 == fa_r[23:0], "R5 held pair",
          {16'h0, l24, r24}, {16'h0, fa_l[23:0], fa_r[23:0]});
    #300;
    check(vld24 && l24 == fa_l[23:0] && r24 == fa_r[23:0], "R5 pair stable while stalled",
          {16'h0, l24, r24}, {16'h0, fa_l[23:0], fa_r[23:0]});
    send_frame(24, fb_l, fb_r);
    flush();
    #1;
    check(vld24 && l24 == fb_l[23:0] && r24 == fb_r[23:0], "R5 newer pair replaces held one",
          {16'h0, l24, r24}, {16'h0, fb_l[23:0], fb_r[23:0]});
    void'(q24.pop_front());
    rdy24 = 1'b1;
    #20;
    check(!vld24, "R5 valid drops after transfer", {63'h0, vld24}, 64'h0);

    // 32 bit clocks per frame: short for 24-bit, full for 16-bit
    send_frame(16, 64'hC3A5, 64'h0F0F);
    flush();
    #1;
    check(err24 == 1'b1, "R6 short half flagged", {63'h0, err24}, 64'h1);
    check(err16 == 1'b0, "R8 16-bit not short", {63'h0, err16}, 64'h0);
    send_frame(32, 64'h1357_9BDF, 64'h2468_ACE0);
    flush();
    #1;
    check(err24 == 1'b1, "R6 error stays set", {63'h0, err24}, 64'h1);

    #200;
    check(q24.size() == 0, "R4 all 24-bit pairs delivered", 64'(q24.size()), 64'h0);
    check(q16.size() == 0, "R4 all 16-bit pairs delivered", 64'(q16.size()), 64'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule